// File: doc/BRIEF.md
# Constant Divider by 2^k±1

This block divides an unsigned dividend by a constant divisor fixed at elaboration time, where the divisor has the form 2^k-1 or 2^k+1 with k of at least 2 (3, 5, 7, 9, 15, 17, 31, 33 and so on). It produces the exact floor quotient and the remainder. It uses only shifts, adders and subtractors. There is no multiplier and no lookup table.

The reciprocal is built in steps. A first estimate takes the dividend shifted right by k. It then adds the dividend shifted right by 2k when the divisor is 2^k-1, or subtracts that term when the divisor is 2^k+1. Each following stage adds to the running estimate a copy of itself shifted right by a distance that doubles from stage to stage: 2k, then 4k, then 8k. Stages are added until the accumulated reciprocal covers the dividend width, so the number of adders grows with the logarithm of that width.

Every truncation in this chain loses value and none adds any, so the integer estimate is never above the true quotient. A closing correction stage works out the remainder N - Q·D, using the constant as a shift plus an add or subtract. It then raises the quotient while the remainder is still at least D. A parameter chooses either a purely combinational path or one register per stage, with a valid flag that travels beside the data. A divisor that is not of the supported form is rejected at elaboration.

Top module: `cdiv_const`

## Requirements
- R1: For every divisor of the form 2^k±1 with k ≥ 2, and every dividend width from 20 to 30 bits, `quotient` equals floor(dividend / DIVISOR).
- R2: `remainder` equals dividend mod DIVISOR and always lies in 0..DIVISOR-1. Its width is ceil(log2(DIVISOR+1)) bits.
- R3: Results are exact at the boundary dividends 0, DIVISOR-1, DIVISOR, DIVISOR+1, 2^WIDTH-2 and 2^WIDTH-1.
- R4: With PIPE=1 the latency is NREF+2 clock cycles. NREF is the smallest count m ≥ 0 for which k·2^(m+1) ≥ WIDTH+1. For DIVISOR=7 and WIDTH=20 this gives NREF=2 and a latency of 4 cycles.
- R5: With PIPE=1, `outValid` is low while `rstN` is low and stays low until the first accepted dividend has passed through the pipeline.
- R6: With PIPE=1, dividends presented on consecutive cycles come out on consecutive cycles, in order, and each is exact.
- R7: With PIPE=1, a cycle with `inValid` low produces `outValid` low exactly the latency later, so gaps in the input stream are kept.
- R8: With PIPE=0 the block is combinational. `outValid` follows `inValid` in the same cycle, and the outputs match the dividend applied in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rstN | input | 1 | Active-low synchronous reset of the valid pipeline |
| inValid | input | 1 | Marks `dividend` as a value to divide |
| dividend | input | WIDTH | Unsigned dividend |
| outValid | output | 1 | Marks `quotient` and `remainder` as a result |
| quotient | output | WIDTH | floor(dividend / DIVISOR) |
| remainder | output | $clog2(DIVISOR+1) | dividend mod DIVISOR |

## Verification
The assertions assume the dividend is stable across the clock edge at which it is captured. The bench meets this by changing inputs only on the falling edge. The assertions also assume the divisor parameter passed the elaboration check, so the estimate chain has enough stages for the width. Every instance in the bench uses a legal divisor with a width between 20 and 30 bits. The combinational instances receive a dense low-range sweep, a sweep down from the maximum dividend, pseudo-random values and every boundary value, while their valid input toggles. The pipelined instance receives a back-to-back stream, a stream with regular gaps, and the boundary values.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int MAX_STG = 8;

  typedef struct packed {
    logic [MAX_STG-1:0] load;
    logic live;
  } cdivStrobe_t;

  // Returns k for a divisor 2^k-1 or 2^k+1 (k >= 2); 0 when unsupported.
  function automatic int findK(input int d);
    for (int k = 2; k <= 30; k++) begin
      if (((1 << k) - 1) == d || ((1 << k) + 1) == d) return k;
    end
    return 0;
  endfunction

  function automatic bit isPlus(input int d);
    int k;
    k = findK(d);
    if (k == 0) return 1'b0;
    return (((1 << k) + 1) == d);
  endfunction

  // Refinement stages needed so that the reciprocal covers w+1 bits.
  function automatic int refineCount(input int k, input int w);
    int m;
    m = 0;
    if (k <= 0) return 0;
    while ((k << (m + 1)) < (w + 1)) m++;
    return m;
  endfunction

endpackage

// File: rtl/cdiv_control.sv
module cdiv_control
  import cdiv_pkg::*;
#(
  parameter int LAT = 4,
  parameter int NSTG = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output cdivStrobe_t strobes,
  output logic        outValid
);

  generate
    if (LAT == 0) begin : g_comb
      always_comb begin
        strobes.load = {MAX_STG{inValid}};
        strobes.live = inValid;
      end
      assign outValid = inValid;
    end else begin : g_pipe
      localparam int IW = $clog2(LAT + 2) + 1;
      logic [LAT-1:0] vPipe;
      logic [IW-1:0]  inFlight;

      always_ff @(posedge clk) begin
        if (!rstN) vPipe <= '0;
        else       vPipe <= {vPipe[LAT-2:0], inValid};
      end

      always_comb begin
        strobes.load = '0;
        strobes.load[0] = inValid;
        for (int i = 1; i < NSTG; i++) strobes.load[i] = vPipe[i-1];
        strobes.live = vPipe[LAT-1];
      end
      assign outValid = vPipe[LAT-1];

      always_ff @(posedge clk) begin
        if (!rstN) inFlight <= '0;
        else inFlight <= inFlight + IW'(inValid) - IW'(outValid);
      end

      AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        inFlight <= IW'(LAT)); // R4
      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        (inFlight == '0) |-> !outValid); // R7
    end
  endgenerate

endmodule

// File: rtl/cdiv_datapath.sv
module cdiv_datapath
  import cdiv_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int DIVISOR = 3,
  parameter int PIPE = 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cdivStrobe_t                    strobes,
  input  logic [WIDTH-1:0]               dividend,
  output logic [WIDTH-1:0]               quotient,
  output logic [$clog2(DIVISOR+1)-1:0]   remainder
);

  localparam int K    = findK(DIVISOR);
  localparam bit PLUS = isPlus(DIVISOR);
  localparam int NREF = refineCount(K, WIDTH);
  localparam int F    = 2 * K + $clog2(WIDTH) + 2;
  localparam int AW   = WIDTH + F;
  localparam int PW   = WIDTH + K + 2;
  localparam int RW   = $clog2(DIVISOR + 1);
  localparam int FIN  = NREF + 1;

  logic [AW-1:0]    accS [NREF+1];
  logic [WIDTH-1:0] nS   [NREF+1];

  // First estimate: N/2^k +/- N/2^2k, exact because F >= 2k.
  logic [AW-1:0] scaled, firstEst;
  assign scaled = {dividend, {F{1'b0}}};
  always_comb begin
    if (PLUS) firstEst = (scaled >> K) - (scaled >> (2 * K));
    else      firstEst = (scaled >> K) + (scaled >> (2 * K));
  end

  generate
    if (PIPE != 0) begin : g_s0
      logic [AW-1:0]    accR;
      logic [WIDTH-1:0] nR;
      always_ff @(posedge clk) begin
        if (strobes.load[0]) begin
          accR <= firstEst;
          nR   <= dividend;
        end
      end
      assign accS[0] = accR;
      assign nS[0]   = nR;
    end else begin : g_s0c
      assign accS[0] = firstEst;
      assign nS[0]   = dividend;
    end

    // Refinement: A <- A + A/2^s, s doubling each stage (2k, 4k, ...).
    for (genvar j = 1; j <= NREF; j++) begin : g_ref
      localparam int SH = K * (1 << j);
      logic [AW-1:0] sumV;
      assign sumV = accS[j-1] + (accS[j-1] >> SH);
      if (PIPE != 0) begin : g_r
        logic [AW-1:0]    accR;
        logic [WIDTH-1:0] nR;
        always_ff @(posedge clk) begin
          if (strobes.load[j]) begin
            accR <= sumV;
            nR   <= nS[j-1];
          end
        end
        assign accS[j] = accR;
        assign nS[j]   = nR;
      end else begin : g_c
        assign accS[j] = sumV;
        assign nS[j]   = nS[j-1];
      end
    end
  endgenerate

  // Correction: remainder by shift-add of the constant, then step up.
  logic [WIDTH-1:0] qEst, qOne, qTwo;
  logic [PW-1:0]    prod, diffA, diffB, diffC;
  logic             unusedFrac;

  assign qEst       = accS[NREF][AW-1:F];
  assign unusedFrac = ^accS[NREF][F-1:0];

  always_comb begin
    if (PLUS) prod = (PW'(qEst) << K) + PW'(qEst);
    else      prod = (PW'(qEst) << K) - PW'(qEst);
    diffA = PW'(nS[NREF]) - prod;
    if (diffA >= PW'(DIVISOR)) begin
      qOne  = qEst + 1'b1;
      diffB = diffA - PW'(DIVISOR);
    end else begin
      qOne  = qEst;
      diffB = diffA;
    end
    if (diffB >= PW'(DIVISOR)) begin
      qTwo  = qOne + 1'b1;
      diffC = diffB - PW'(DIVISOR);
    end else begin
      qTwo  = qOne;
      diffC = diffB;
    end
  end

  generate
    if (PIPE != 0) begin : g_fin
      always_ff @(posedge clk) begin
        if (strobes.load[FIN]) begin
          quotient  <= qTwo;
          remainder <= diffC[RW-1:0];
        end
      end
    end else begin : g_finc
      assign quotient  = qTwo;
      assign remainder = diffC[RW-1:0];
    end
  endgenerate

  AST_EST_NOT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[FIN] |-> (prod <= PW'(nS[NREF]))); // R1
  AST_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[FIN] |->
      (64'(qTwo) * 64'(DIVISOR) + 64'(diffC) == 64'(nS[NREF]))); // R1
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load[FIN] |-> (diffC < PW'(DIVISOR))); // R2

endmodule

// File: rtl/cdiv_const.sv
module cdiv_const
  import cdiv_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int DIVISOR = 3,
  parameter int PIPE = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [WIDTH-1:0]             dividend,
  output logic                         outValid,
  output logic [WIDTH-1:0]             quotient,
  output logic [$clog2(DIVISOR+1)-1:0] remainder
);

  localparam int K    = findK(DIVISOR);
  localparam int NREF = refineCount(K, WIDTH);
  localparam int NSTG = NREF + 2;
  localparam int LAT  = (PIPE != 0) ? NSTG : 0;

  generate
    if (K == 0) begin : g_bad_divisor
      $error("cdiv_const: DIVISOR must equal 2^k-1 or 2^k+1 with k >= 2");
    end
    if (WIDTH < 2 || NSTG > MAX_STG) begin : g_bad_width
      $error("cdiv_const: WIDTH out of supported range");
    end
  endgenerate

  cdivStrobe_t strobes;

  cdiv_control #(.LAT(LAT), .NSTG(NSTG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  cdiv_datapath #(.WIDTH(WIDTH), .DIVISOR(DIVISOR), .PIPE(PIPE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dividend(dividend),
    .quotient(quotient), .remainder(remainder)
  );

endmodule

// File: tb/cdiv_const_test.sv
module cdiv_const_test;

  localparam int CW = 30;
  localparam int NDIV = 6;
  localparam int DIVS [NDIV] = '{3, 5, 7, 9, 15, 17};
  localparam int PW = 20;
  localparam int PD = 7;
  // R4: k=3, W=20 -> smallest m with 3*2^(m+1) >= 21 is 2; latency 2+2.
  localparam int PLAT = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Combinational instances, one per divisor, 30-bit dividend.
  logic          combValid = 1'b0;
  logic [CW-1:0] combN = '0;
  logic [CW-1:0] combQ [NDIV];
  logic [7:0]    combR [NDIV];
  logic          combV [NDIV];

  for (genvar j = 0; j < NDIV; j++) begin : g_comb
    localparam int DV  = DIVS[j];
    localparam int RWJ = $clog2(DV + 1);
    logic [CW-1:0]  qj;
    logic [RWJ-1:0] rj;
    logic           vj;
    cdiv_const #(.WIDTH(CW), .DIVISOR(DV), .PIPE(0)) uutC (
      .clk(clk), .rstN(rstN), .inValid(combValid), .dividend(combN),
      .outValid(vj), .quotient(qj), .remainder(rj)
    );
    assign combQ[j] = qj;
    assign combR[j] = 8'(rj);
    assign combV[j] = vj;
  end

  // Pipelined instance under test.
  logic          pipeValid = 1'b0;
  logic [PW-1:0] pipeN = '0;
  logic          pipeOutV;
  logic [PW-1:0] pipeQ;
  logic [2:0]    pipeR;

  cdiv_const #(.WIDTH(PW), .DIVISOR(PD), .PIPE(1)) uut (
    .clk(clk), .rstN(rstN), .inValid(pipeValid), .dividend(pipeN),
    .outValid(pipeOutV), .quotient(pipeQ), .remainder(pipeR)
  );

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic checkVal(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Apply one dividend to the combinational instances and check all six.
  task automatic combStep(input logic [CW-1:0] n, input logic v, input string tag);
    @(negedge clk);
    combN = n;
    combValid = v;
    #2;
    for (int j = 0; j < NDIV; j++) begin
      longint dv = longint'(DIVS[j]);
      checkVal({tag, " R1 quotient"}, longint'(combQ[j]), longint'(n) / dv);
      checkVal({tag, " R2 remainder"}, longint'(combR[j]), longint'(n) % dv);
      checkVal("R8 outValid follows inValid", longint'(combV[j]), longint'(v));
    end
  endtask

  // Pipelined scoreboard indexed by capture edge.
  int cyc = 0;
  bit seenOut = 1'b0;
  logic          histV [32];
  logic [PW-1:0] histN [32];

  task automatic pipeStep(input logic v, input logic [PW-1:0] n);
    int idx;
    logic expV;
    logic [PW-1:0] expN;
    @(negedge clk);
    cyc++;
    idx = cyc - PLAT + 1;
    expV = (idx >= 0) ? histV[idx % 32] : 1'b0;
    expN = (idx >= 0) ? histN[idx % 32] : '0;
    if (!seenOut) checkVal("R5 outValid quiet before first result", longint'(pipeOutV), longint'(expV));
    else          checkVal("R4 R7 outValid timing", longint'(pipeOutV), longint'(expV));
    if (expV && pipeOutV) begin
      seenOut = 1'b1;
      checkVal("R6 streamed quotient", longint'(pipeQ), longint'(expN) / PD);
      checkVal("R2 streamed remainder", longint'(pipeR), longint'(expN) % PD);
    end
    pipeValid = v;
    pipeN = n;
    histV[(cyc + 1) % 32] = v;
    histN[(cyc + 1) % 32] = n;
  endtask

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    for (int i = 0; i < 32; i++) begin
      histV[i] = 1'b0;
      histN[i] = '0;
    end

    // Reset state (R5): pipeline valid low during and right after reset.
    repeat (4) @(negedge clk);
    checkVal("R5 outValid low in reset", longint'(pipeOutV), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R5 outValid low after reset", longint'(pipeOutV), 0);

    // R3: boundary dividends for every divisor.
    for (int j = 0; j < NDIV; j++) begin
      combStep(CW'(0), 1'b1, "R3 zero");
      combStep(CW'(DIVS[j] - 1), 1'b0, "R3 D-1");
      combStep(CW'(DIVS[j]), 1'b1, "R3 D");
      combStep(CW'(DIVS[j] + 1), 1'b0, "R3 D+1");
    end
    combStep({CW{1'b1}}, 1'b1, "R3 max");
    combStep({CW{1'b1}} - 1'b1, 1'b0, "R3 max-1");

    // R1: dense low sweep, high sweep, pseudo-random values.
    for (int i = 0; i < 30000; i++) combStep(CW'(i), 1'(i), "R1 low");
    for (int i = 0; i < 4000; i++) combStep({CW{1'b1}} - CW'(i), 1'(i), "R1 high");
    for (int i = 0; i < 16000; i++) begin
      seed = xs32(seed);
      combStep(seed[CW-1:0], 1'(i >> 1), "R1 random");
    end

    // Pipelined: R6 back-to-back stream.
    for (int i = 0; i < 6000; i++) pipeStep(1'b1, PW'(i * 173));
    // R7: gaps every third cycle.
    for (int i = 0; i < 4000; i++) begin
      seed = xs32(seed);
      pipeStep((i % 3) != 0, seed[PW-1:0]);
    end
    // R3 boundaries through the pipeline.
    pipeStep(1'b1, PW'(0));
    pipeStep(1'b1, PW'(PD - 1));
    pipeStep(1'b1, PW'(PD));
    pipeStep(1'b0, PW'(PD + 1));
    pipeStep(1'b1, PW'(PD + 1));
    pipeStep(1'b1, {PW{1'b1}} - 1'b1);
    pipeStep(1'b1, {PW{1'b1}});
    for (int i = 0; i < PLAT + 2; i++) pipeStep(1'b0, '0);
    checkVal("R7 drained", longint'(pipeOutV), 0);

    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

endmodule